// File: doc/BRIEF.md
# Forwarding Dual-Port RAM

This block is a single-clock memory with one write port and one read port. It is meant as a register file or scratch buffer inside a pipeline. A write presented in a cycle lands in the array at the next rising clock edge. The read port works in one of two modes, chosen by a parameter.

In registered-read mode, the word addressed in one cycle appears on the output one cycle later. If a write goes to the same location in the same cycle, a forwarding path returns the incoming write data rather than the word the array still holds. In combinational-read mode, the output follows the read address within the cycle. No forwarding is applied there, because a write is not visible until the edge that stores it.

Address width and data width are parameters, and the depth is two to the power of the address width. Array contents after reset are undefined, so users must write a location before relying on it.

Top module: `fwd_ram`

## Requirements
- R1: With `RD_MODE = RD_SYNC`, when `rd_en` is high and there is no collision, the word at `rd_addr` appears on `rd_data` after the next rising edge, one cycle of latency.
- R2: A write with `wr_en` high is stored at the next rising edge. Any read issued after that edge returns `wr_data` for `wr_addr`.
- R3: With `RD_MODE = RD_SYNC`, if `rd_en` and `wr_en` are both high and `wr_addr` equals `rd_addr`, the next `rd_data` is the `wr_data` of that cycle.
- R4: With `RD_MODE = RD_SYNC`, when `wr_en` is low or the two addresses differ, a read returns the stored word, unaffected by `wr_data`.
- R5: With `RD_MODE = RD_SYNC`, while `rd_en` is low, `rd_data` keeps its previous value whatever the write port does.
- R6: With `RD_MODE = RD_ASYNC`, `rd_data` equals the stored word at `rd_addr` within the same cycle, with no clock edge in between. `rd_en` is ignored.
- R7: With `RD_MODE = RD_ASYNC`, a write to the location being read in the same cycle does not change `rd_data` before the clock edge. The old word is shown until then.
- R8: With `RD_MODE = RD_SYNC`, a low `rst_n` clears the read data register to zero. The array contents are not cleared.
- R9: The array holds `2**ADDR_W` independent words of `DATA_W` bits each. Every address is reachable and distinct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Active-low synchronous reset of the read register |
| wr_en | input | 1 | Write request |
| wr_addr | input | ADDR_W | Write location |
| wr_data | input | DATA_W | Word to store |
| rd_en | input | 1 | Read request; used in registered mode only |
| rd_addr | input | ADDR_W | Read location |
| rd_data | output | DATA_W | Read result |

## Verification
Two instances, one per read mode, receive the same stimulus. The first pattern is a full write sweep followed by a full read sweep with a distinct value per address. This separates address decoding faults and latency errors from forwarding faults. Then, for every address, a read is paired with a same-address write, with the write disabled, and with a write to a different address. These three cases separate a correct bypass from a missing, always-on or address-blind one, and they show in the combinational instance that the old word stays visible until the edge. Last comes random traffic with regular forced collisions and stretches with reads disabled. This exercises the hold behaviour and the interaction of back-to-back writes and reads.

// File: rtl/fwdram_pkg.sv
package fwdram_pkg;

  typedef enum logic {
    RD_ASYNC = 1'b0,
    RD_SYNC  = 1'b1
  } rd_mode_e;

endpackage

// File: rtl/fwdram_store.sv
module fwdram_store #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] wa,
  input  logic [DATA_W-1:0] wd,
  input  logic [ADDR_W-1:0] ra,
  output logic [DATA_W-1:0] rword
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[wa] <= wd;
  end

  assign rword = cells[ra];

  // R2: a write lands at the following edge
  a_r2_commit: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (cells[$past(wa)] == $past(wd)));

endmodule

// File: rtl/fwdram_fwd.sv
module fwdram_fwd #(
  parameter int ADDR_W = 4
) (
  input  logic              we,
  input  logic [ADDR_W-1:0] wa,
  input  logic [ADDR_W-1:0] ra,
  output logic              hit
);
  function automatic logic collide(input logic en,
                                   input logic [ADDR_W-1:0] a,
                                   input logic [ADDR_W-1:0] b);
    return en && (a == b);
  endfunction

  assign hit = collide(we, wa, ra);
endmodule

// File: rtl/fwdram_rdreg.sv
module fwdram_rdreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              hit,
  input  logic [DATA_W-1:0] wd,
  input  logic [DATA_W-1:0] rword,
  output logic [DATA_W-1:0] q
);
  function automatic logic [DATA_W-1:0] pick(input logic h,
                                             input logic [DATA_W-1:0] fresh,
                                             input logic [DATA_W-1:0] stored);
    return h ? fresh : stored;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)     q <= '0;
    else if (rd_en) q <= pick(hit, wd, rword);
  end

  a_r3_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && hit) |=> (q == $past(wd)));

  a_r4_stored: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !hit) |=> (q == $past(rword)));

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(q));
endmodule

// File: rtl/fwd_ram.sv
module fwd_ram #(
  parameter int                   ADDR_W  = 4,
  parameter int                   DATA_W  = 8,
  parameter fwdram_pkg::rd_mode_e RD_MODE = fwdram_pkg::RD_SYNC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  import fwdram_pkg::*;

  logic [DATA_W-1:0] stored_word;
  logic              fwd_hit;

  fwdram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (wr_en),
    .wa   (wr_addr),
    .wd   (wr_data),
    .ra   (rd_addr),
    .rword(stored_word)
  );

  fwdram_fwd #(.ADDR_W(ADDR_W)) u_fwd (
    .we (wr_en),
    .wa (wr_addr),
    .ra (rd_addr),
    .hit(fwd_hit)
  );

  // R2: a colliding write is seen by the array one edge later
  a_r2_visible: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_hit |=> (rd_addr != $past(rd_addr) || stored_word == $past(wr_data)));

  generate
    if (RD_MODE == RD_SYNC) begin : g_sync
      fwdram_rdreg #(.DATA_W(DATA_W)) u_rdreg (
        .clk  (clk),
        .rst_n(rst_n),
        .rd_en(rd_en),
        .hit  (fwd_hit),
        .wd   (wr_data),
        .rword(stored_word),
        .q    (rd_data)
      );

      // R1: one cycle of latency on a plain read
      a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en) |=> (rd_data == $past(stored_word)));
    end else begin : g_async
      assign rd_data = stored_word;

      // R7: a write shows up only after its edge
      a_r7_no_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_addr != $past(wr_addr) || rd_data == $past(wr_data)));
    end
  endgenerate
endmodule

// File: tb/fwd_ram_test.sv
module fwd_ram_test;
  import fwdram_pkg::*;

  localparam int AW    = 4;
  localparam int DW    = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data_s;
  logic [DW-1:0] rd_data_a;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [DW-1:0] model [DEPTH];
  bit            known [DEPTH];
  logic [DW-1:0] exp_s = '0;
  bit            exp_s_known = 1;

  always #10 clk = ~clk;

  fwd_ram #(.ADDR_W(AW), .DATA_W(DW), .RD_MODE(RD_SYNC)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data_s));

  fwd_ram #(.ADDR_W(AW), .DATA_W(DW), .RD_MODE(RD_ASYNC)) uut_async (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data_a));

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] pattern(input int a, input int salt);
    return DW'((a * 37 + salt * 11 + 5) & ((1 << DW) - 1));
  endfunction

  task automatic step(input bit we, input int wa, input logic [DW-1:0] wd,
                      input bit re, input int ra);
    @(negedge clk);
    wr_en = we; wr_addr = AW'(wa); wr_data = wd;
    rd_en = re; rd_addr = AW'(ra);
    #1;
    if (known[ra]) begin
      if (we && wa == ra) check("R7 old word before edge", rd_data_a, model[ra]);
      else                check("R6 combinational read", rd_data_a, model[ra]);
    end
    if (re) begin
      if (we && wa == ra) begin exp_s = wd; exp_s_known = 1; end
      else begin exp_s = model[ra]; exp_s_known = known[ra]; end
    end
    @(posedge clk); #1;
    if (we) begin model[wa] = wd; known[wa] = 1; end
    if (exp_s_known) begin
      if (!re)                 check("R5 hold", rd_data_s, exp_s);
      else if (we && wa == ra) check("R3 forward", rd_data_s, exp_s);
      else if (we)             check("R4 other address", rd_data_s, exp_s);
      else                     check("R1 latency", rd_data_s, exp_s);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual running expected done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) known[i] = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R8 reset value", rd_data_s, '0);
    @(negedge clk); rst_n = 1'b1;

    // R9: fill every address with a distinct word, reads off (R5)
    for (int a = 0; a < DEPTH; a++) step(1, a, pattern(a, 0), 0, 0);
    // R9 and R2: read every address back in both modes
    for (int a = 0; a < DEPTH; a++) step(0, 0, '0, 1, a);

    // R3 collision, R4 write disabled, R4 different address
    for (int a = 0; a < DEPTH; a++) begin
      step(1, a, pattern(a, 1), 1, a);
      step(0, a, pattern(a, 2), 1, a);
      step(1, (a + 1) % DEPTH, pattern(a, 3), 1, a);
      step(0, 0, '0, 1, (a + 1) % DEPTH); // R2 landed
    end

    // R5: write the location the stale register came from, reads off
    step(1, 3, 8'hA5, 1, 3);
    step(1, 3, 8'h5A, 0, 3);
    step(1, 3, 8'h3C, 0, 7);

    // random traffic with forced collisions
    for (int n = 0; n < 3000; n++) begin
      int wa = $urandom_range(DEPTH - 1);
      int ra = (n % 4 == 0) ? wa : int'($urandom_range(DEPTH - 1));
      step(($urandom_range(3) != 0), wa, DW'($urandom),
           ($urandom_range(4) != 0), ra);
    end

    // R8: reset mid-run clears only the register
    @(negedge clk); rst_n = 1'b0; wr_en = 0; rd_en = 0;
    @(posedge clk); #1;
    check("R8 reset clears register", rd_data_s, '0);
    @(negedge clk); rst_n = 1'b1;
    exp_s = '0; exp_s_known = 1;
    for (int a = 0; a < DEPTH; a++) step(0, 0, '0, 1, a);

    finish_run();
  end
endmodule